// File: doc/BRIEF.md
# Banked Chip-Select Decoder with Wait-State Timing

This block sits between a simple bus master and a set of peripheral banks. Each bank has a base word and an option word, written through a small register port. When the master starts an access, the upper address bits are compared with each valid bank's base under that bank's mask. The lowest-numbered matching bank wins. If that bank is assigned to this block's timing machine, the block drives its chip select, counts the bank's wait states and then returns a transfer acknowledge. A peripheral can also end the access early with an external acknowledge.

An access that hits no bank, or a write to a write-protected bank, ends with a one-cycle error pulse and no chip select. A bank marked for a different machine, such as an SDRAM controller, is decoded and its attributes are reported, but this block leaves the access alone. For every accepted hit the bank's port-size and machine-select codes are presented on attribute outputs.

Top module: `csw_chip_select`

## Requirements
- R1: After reset every chip select, `ack` and `err` are low, and every bank is invalid, so a start to any address gives an error pulse.
- R2: Base word layout: bits 31:15 base, 12:11 port size, 10 write protect, 9:7 machine select, 0 valid. Option word layout: bits 31:15 mask, 11:8 wait count, 7 external-only. A bank matches when `((addr[31:15] ^ base) & mask) == 0`. An all-ones mask gives a 32 KB window.
- R3: A bank whose valid bit is 0 never matches.
- R4: When several valid banks match, the lowest-numbered one is selected.
- R5: For a timed bank with wait count N, the bank's chip select is high from the first cycle after the start is sampled through cycle 1+N. `ack` pulses in cycle 1+N, and the chip select is low in cycle 2+N. With N=0 the acknowledge comes in cycle 1.
- R6: If `ext_ack` is sampled high in an access cycle that has no acknowledge yet, `ack` is issued in the next cycle, ahead of the wait count.
- R7: With the external-only bit set, no internal acknowledge is generated. The access is held until `ext_ack` arrives.
- R8: A write to a bank whose write-protect bit is 1 gives `err` in cycle 1 with no chip select. Reads of that bank proceed normally.
- R9: A start whose address matches no valid bank gives a one-cycle `err` in cycle 1 with no chip select.
- R10: A matching bank with a machine-select code other than 000 (for example 010, SDRAM) produces no chip select, no `ack` and no `err`.
- R11: On an accepted hit, `attr_ps` and `attr_ms` show that bank's port size (11 = 32-bit, 00 = 64-bit) and machine select from cycle 1 onward.
- R12: A start raised while an access is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Bank register write strobe |
| reg_bank | input | BANK_W | Bank index for the write |
| reg_opt | input | 1 | 0 writes the base word, 1 writes the option word |
| reg_wdata | input | 32 | Register write data |
| bus_start | input | 1 | Access start, sampled while idle |
| bus_write | input | 1 | 1 for a write access |
| bus_addr | input | ADDR_W | Access address |
| ext_ack | input | 1 | External acknowledge from the peripheral |
| cs | output | NUM_BANKS | One-hot chip selects, active high |
| ack | output | 1 | Transfer acknowledge pulse |
| err | output | 1 | Error pulse for a miss or a protected write |
| attr_ps | output | 2 | Port size of the last accepted bank |
| attr_ms | output | 3 | Machine select of the last accepted bank |

## Verification
Every output is registered, so the results of a start sampled on one edge appear from the next cycle, called cycle 1. The chip select appears in cycle 1, `err` also appears in cycle 1, and `ack` is due in cycle 1+N, or in the cycle after `ext_ack` is sampled. The bench drives inputs on falling edges and checks outputs at the following falling edge. It walks cycle by cycle and checks chip select, `ack` and `err` in every cycle up to and including the cycle after the acknowledge. Early-acknowledge and ignored-start cases are checked across the whole access window.

// File: rtl/csw_pkg.sv
package csw_pkg;
  localparam int DATA_W  = 32;
  localparam int MATCH_W = 17;
  localparam int WAIT_W  = 4;
  localparam int PS_W    = 2;
  localparam int MS_W    = 3;

  localparam int FLD_LSB   = DATA_W - MATCH_W;
  localparam int PS_LSB    = 11;
  localparam int WP_BIT    = 10;
  localparam int MS_LSB    = 7;
  localparam int VALID_BIT = 0;
  localparam int WAIT_LSB  = 8;
  localparam int EXTO_BIT  = 7;

  localparam logic [MS_W-1:0] MS_TIMED = 3'b000;

  typedef struct packed {
    logic               valid;
    logic [MATCH_W-1:0] base;
    logic [MATCH_W-1:0] mask;
    logic [PS_W-1:0]    ps;
    logic               wp;
    logic [MS_W-1:0]    ms;
    logic [WAIT_W-1:0]  nwait;
    logic               ext_only;
  } bank_cfg_t;

  typedef enum logic {ST_IDLE, ST_ACCESS} acc_state_t;
endpackage

// File: rtl/csw_bank_regs.sv
module csw_bank_regs
  import csw_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [BANK_W-1:0] reg_bank,
  input  logic              reg_opt,
  input  logic [DATA_W-1:0] reg_wdata,
  output bank_cfg_t         cfg [NUM_BANKS]
);
  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[FLD_LSB-1:PS_LSB+PS_W], reg_wdata[MS_LSB-1:VALID_BIT+1]};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_cfg_t r;
    always_ff @(posedge clk) begin
      if (rst) begin
        r <= '0;
      end else if (reg_we && reg_bank == BANK_W'(b)) begin
        if (reg_opt) begin
          r.mask     <= reg_wdata[DATA_W-1:FLD_LSB];
          r.nwait    <= reg_wdata[WAIT_LSB +: WAIT_W];
          r.ext_only <= reg_wdata[EXTO_BIT];
        end else begin
          r.base  <= reg_wdata[DATA_W-1:FLD_LSB];
          r.ps    <= reg_wdata[PS_LSB +: PS_W];
          r.wp    <= reg_wdata[WP_BIT];
          r.ms    <= reg_wdata[MS_LSB +: MS_W];
          r.valid <= reg_wdata[VALID_BIT];
        end
      end
    end
    assign cfg[b] = r;
  end
endmodule

// File: rtl/csw_decode.sv
module csw_decode
  import csw_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic [MATCH_W-1:0] addr_fld,
  input  bank_cfg_t          cfg [NUM_BANKS],
  output logic               hit,
  output logic [NUM_BANKS-1:0] hit_oh,
  output logic [WAIT_W-1:0]  sel_nwait,
  output logic               sel_ext_only,
  output logic               sel_wp,
  output logic [MS_W-1:0]    sel_ms,
  output logic [PS_W-1:0]    sel_ps
);
  logic [NUM_BANKS-1:0] match;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
    assign match[b] = cfg[b].valid && (((addr_fld ^ cfg[b].base) & cfg[b].mask) == '0);
  end

  always_comb begin
    hit          = |match;
    hit_oh       = '0;
    sel_nwait    = '0;
    sel_ext_only = 1'b0;
    sel_wp       = 1'b0;
    sel_ms       = '0;
    sel_ps       = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_oh       = '0;
        hit_oh[i]    = 1'b1;
        sel_nwait    = cfg[i].nwait;
        sel_ext_only = cfg[i].ext_only;
        sel_wp       = cfg[i].wp;
        sel_ms       = cfg[i].ms;
        sel_ps       = cfg[i].ps;
      end
    end
  end
endmodule

// File: rtl/csw_timer.sv
module csw_timer
  import csw_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_start,
  input  logic                 bus_write,
  input  logic                 ext_ack,
  input  logic                 hit,
  input  logic [NUM_BANKS-1:0] hit_oh,
  input  logic [WAIT_W-1:0]    sel_nwait,
  input  logic                 sel_ext_only,
  input  logic                 sel_wp,
  input  logic [MS_W-1:0]      sel_ms,
  input  logic [PS_W-1:0]      sel_ps,
  output logic [NUM_BANKS-1:0] cs,
  output logic                 ack,
  output logic                 err,
  output logic [PS_W-1:0]      attr_ps,
  output logic [MS_W-1:0]      attr_ms
);
  acc_state_t          state;
  logic [WAIT_W-1:0]   cnt;
  logic                ext_only_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      ext_only_q <= 1'b0;
      cs         <= '0;
      ack        <= 1'b0;
      err        <= 1'b0;
      attr_ps    <= '0;
      attr_ms    <= '0;
    end else begin
      err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (bus_start) begin
            if (!hit || (bus_write && sel_wp)) begin
              err <= 1'b1;
            end else begin
              attr_ps <= sel_ps;
              attr_ms <= sel_ms;
              if (sel_ms == MS_TIMED) begin
                cs         <= hit_oh;
                cnt        <= sel_nwait;
                ext_only_q <= sel_ext_only;
                ack        <= (sel_nwait == '0) && !sel_ext_only;
                state      <= ST_ACCESS;
              end
            end
          end
        end
        ST_ACCESS: begin
          if (ack) begin
            ack   <= 1'b0;
            cs    <= '0;
            state <= ST_IDLE;
          end else begin
            if (ext_ack || (!ext_only_q && cnt <= WAIT_W'(1))) ack <= 1'b1;
            if (cnt != '0) cnt <= cnt - WAIT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csw_chip_select.sv
module csw_chip_select
  import csw_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 32,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic [BANK_W-1:0]    reg_bank,
  input  logic                 reg_opt,
  input  logic [31:0]          reg_wdata,
  input  logic                 bus_start,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 ext_ack,
  output logic [NUM_BANKS-1:0] cs,
  output logic                 ack,
  output logic                 err,
  output logic [1:0]           attr_ps,
  output logic [2:0]           attr_ms
);
  bank_cfg_t            cfg [NUM_BANKS];
  logic                 hit;
  logic [NUM_BANKS-1:0] hit_oh;
  logic [WAIT_W-1:0]    sel_nwait;
  logic                 sel_ext_only, sel_wp;
  logic [MS_W-1:0]      sel_ms;
  logic [PS_W-1:0]      sel_ps;
  logic                 unused_addr;

  assign unused_addr = ^bus_addr[ADDR_W-MATCH_W-1:0];

  csw_bank_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_bank(reg_bank),
    .reg_opt(reg_opt), .reg_wdata(reg_wdata), .cfg(cfg)
  );

  csw_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .addr_fld(bus_addr[ADDR_W-1 -: MATCH_W]), .cfg(cfg), .hit(hit), .hit_oh(hit_oh),
    .sel_nwait(sel_nwait), .sel_ext_only(sel_ext_only), .sel_wp(sel_wp),
    .sel_ms(sel_ms), .sel_ps(sel_ps)
  );

  csw_timer #(.NUM_BANKS(NUM_BANKS)) u_tmr (
    .clk(clk), .rst(rst), .bus_start(bus_start), .bus_write(bus_write),
    .ext_ack(ext_ack), .hit(hit), .hit_oh(hit_oh), .sel_nwait(sel_nwait),
    .sel_ext_only(sel_ext_only), .sel_wp(sel_wp), .sel_ms(sel_ms), .sel_ps(sel_ps),
    .cs(cs), .ack(ack), .err(err), .attr_ps(attr_ps), .attr_ms(attr_ms)
  );
endmodule

// File: rtl/csw_chip_select_chk.sv
module csw_chip_select_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_BANKS-1:0] cs,
  input logic                 ack,
  input logic                 err,
  input logic                 ext_ack
);
  // R4: never more than one chip select
  a_r4_cs_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(cs));
  // R5: acknowledge only while exactly one bank is selected
  a_r5_ack_with_cs: assert property (@(posedge clk) disable iff (rst) ack |-> ($countones(cs) == 1));
  // R5: chip select released the cycle after acknowledge
  a_r5_cs_release: assert property (@(posedge clk) disable iff (rst) ack |=> (cs == '0 && !ack));
  // R12: chip select holds steady during an access
  a_r12_cs_hold: assert property (@(posedge clk) disable iff (rst) (|cs && !ack) |=> (cs == $past(cs)));
  // R6: external acknowledge ends the access in the next cycle
  a_r6_ext_early: assert property (@(posedge clk) disable iff (rst) (|cs && !ack && ext_ack) |=> ack);
  // R8, R9: error never coincides with a chip select
  a_r9_err_no_cs: assert property (@(posedge clk) disable iff (rst) err |-> (cs == '0 && !ack));
endmodule

bind csw_chip_select csw_chip_select_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .ack(ack), .err(err), .ext_ack(ext_ack)
);

// File: tb/csw_chip_select_bench.sv
`timescale 1ns/1ps
module csw_chip_select_bench;
  localparam int NB = 4;
  logic clk = 0, rst = 1;
  logic reg_we = 0, reg_opt = 0;
  logic [1:0] reg_bank = '0;
  logic [31:0] reg_wdata = '0;
  logic bus_start = 0, bus_write = 0, ext_ack = 0;
  logic [31:0] bus_addr = '0;
  logic [NB-1:0] cs;
  logic ack, err;
  logic [1:0] attr_ps;
  logic [2:0] attr_ms;
  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  csw_chip_select u_csw_chip_select (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_bank(reg_bank), .reg_opt(reg_opt),
    .reg_wdata(reg_wdata), .bus_start(bus_start), .bus_write(bus_write),
    .bus_addr(bus_addr), .ext_ack(ext_ack), .cs(cs), .ack(ack), .err(err),
    .attr_ps(attr_ps), .attr_ms(attr_ms)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_base(input int b, input logic [31:0] addr, input logic [1:0] ps,
                         input logic wp, input logic [2:0] ms, input logic v);
    @(negedge clk);
    reg_we = 1; reg_opt = 0; reg_bank = 2'(b);
    reg_wdata = {addr[31:15], 2'b00, ps, wp, ms, 6'b0, v};
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic wr_opt(input int b, input logic [16:0] mask, input logic [3:0] nw, input logic eo);
    @(negedge clk);
    reg_we = 1; reg_opt = 1; reg_bank = 2'(b);
    reg_wdata = {mask, 3'b000, nw, eo, 7'b0};
    @(negedge clk);
    reg_we = 0;
  endtask

  // Leaves the bench at the falling edge inside cycle 1
  task automatic start_acc(input logic [31:0] a, input logic w);
    @(negedge clk);
    bus_start = 1; bus_addr = a; bus_write = w;
    @(negedge clk);
    bus_start = 0; bus_write = 0;
  endtask

  task automatic timed_access(input string req, input logic [31:0] a, input logic w,
                              input int bank, input int nw);
    start_acc(a, w);
    for (int c = 1; c <= nw + 1; c++) begin
      chk(req, $sformatf("cs cycle %0d", c), 32'(cs), 32'(1 << bank));
      chk(req, $sformatf("ack cycle %0d", c), 32'(ack), 32'(c == nw + 1));
      chk(req, $sformatf("err cycle %0d", c), 32'(err), 0);
      @(negedge clk);
    end
    chk(req, "cs after ack", 32'(cs), 0);
    chk(req, "ack after ack", 32'(ack), 0);
  endtask

  task automatic err_access(input string req, input logic [31:0] a, input logic w);
    start_acc(a, w);
    chk(req, "err cycle 1", 32'(err), 1);
    chk(req, "cs cycle 1", 32'(cs), 0);
    chk(req, "ack cycle 1", 32'(ack), 0);
    @(negedge clk);
    chk(req, "err cycle 2", 32'(err), 0);
  endtask

  task automatic t_reset;
    chk("R1", "cs reset", 32'(cs), 0);
    chk("R1", "ack reset", 32'(ack), 0);
    chk("R1", "err reset", 32'(err), 0);
    err_access("R1", 32'h0000_0000, 0);
  endtask

  task automatic t_config;
    wr_base(0, 32'h0450_0000, 2'b11, 0, 3'b000, 1);
    wr_opt (0, 17'h1FFFF, 4'd1, 0);
    wr_base(1, 32'h0800_0000, 2'b00, 1, 3'b000, 1);
    wr_opt (1, 17'h1F800, 4'd3, 0);
    wr_base(2, 32'h0900_0000, 2'b01, 0, 3'b000, 1);
    wr_opt (2, 17'h1FFFF, 4'd0, 0);
    wr_base(3, 32'h1000_0000, 2'b00, 0, 3'b010, 1);
    wr_opt (3, 17'h1FFFF, 4'd2, 0);
  endtask

  task automatic t_window;
    timed_access("R2", 32'h0450_7FFC, 0, 0, 1);
    chk("R11", "port size bank0", 32'(attr_ps), 3);
    chk("R11", "machine bank0", 32'(attr_ms), 0);
    err_access("R9", 32'h0450_8000, 0);
  endtask

  task automatic t_prio_and_wp;
    timed_access("R4", 32'h0900_0000, 0, 1, 3);
    chk("R11", "port size bank1", 32'(attr_ps), 0);
    err_access("R8", 32'h0A00_0000, 1);
    timed_access("R5", 32'h0A00_0000, 0, 1, 3);
  endtask

  task automatic t_ext_early;
    @(negedge clk);
    bus_start = 1; bus_addr = 32'h0A00_0000; bus_write = 0;
    @(negedge clk);
    bus_start = 0; ext_ack = 1;
    chk("R6", "cs cycle 1", 32'(cs), 32'b0010);
    chk("R6", "ack cycle 1", 32'(ack), 0);
    @(negedge clk);
    ext_ack = 0;
    chk("R6", "ack cycle 2", 32'(ack), 1);
    chk("R6", "cs cycle 2", 32'(cs), 32'b0010);
    @(negedge clk);
    chk("R6", "cs cycle 3", 32'(cs), 0);
    chk("R6", "ack cycle 3", 32'(ack), 0);
  endtask

  task automatic t_ignored_start;
    @(negedge clk);
    bus_start = 1; bus_addr = 32'h0A00_0000; bus_write = 0;
    @(negedge clk);
    bus_addr = 32'h0450_0000;
    chk("R12", "cs cycle 1", 32'(cs), 32'b0010);
    @(negedge clk);
    bus_start = 0;
    for (int c = 2; c <= 4; c++) begin
      chk("R12", $sformatf("cs cycle %0d", c), 32'(cs), 32'b0010);
      chk("R12", $sformatf("ack cycle %0d", c), 32'(ack), 32'(c == 4));
      chk("R12", $sformatf("err cycle %0d", c), 32'(err), 0);
      @(negedge clk);
    end
    chk("R12", "cs idle", 32'(cs), 0);
    @(negedge clk);
    chk("R12", "no late access", 32'(cs), 0);
  endtask

  task automatic t_other_machine;
    start_acc(32'h1000_0100, 0);
    for (int c = 1; c <= 4; c++) begin
      chk("R10", $sformatf("cs cycle %0d", c), 32'(cs), 0);
      chk("R10", $sformatf("ack cycle %0d", c), 32'(ack), 0);
      chk("R10", $sformatf("err cycle %0d", c), 32'(err), 0);
      @(negedge clk);
    end
    chk("R11", "machine select bank3", 32'(attr_ms), 32'b010);
    chk("R11", "port size bank3", 32'(attr_ps), 0);
  endtask

  task automatic t_invalid_and_zero_wait;
    wr_base(1, 32'h0800_0000, 2'b00, 1, 3'b000, 0);
    timed_access("R3", 32'h0900_0000, 0, 2, 0);
    err_access("R3", 32'h0A00_0000, 0);
  endtask

  task automatic t_ext_only;
    wr_opt(0, 17'h1FFFF, 4'd0, 1);
    start_acc(32'h0450_0010, 1);
    for (int c = 1; c <= 3; c++) begin
      chk("R7", $sformatf("cs cycle %0d", c), 32'(cs), 32'b0001);
      chk("R7", $sformatf("ack cycle %0d", c), 32'(ack), 0);
      if (c == 3) ext_ack = 1;
      @(negedge clk);
    end
    ext_ack = 0;
    chk("R7", "ack cycle 4", 32'(ack), 1);
    @(negedge clk);
    chk("R7", "cs released", 32'(cs), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_config;
    t_window;
    t_prio_and_wp;
    t_ext_early;
    t_ignored_start;
    t_other_machine;
    t_invalid_and_zero_wait;
    t_ext_only;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule